// File: doc/BRIEF.md
# CAN Mode Handshake and Wake-Up Filter

This block manages the configuration and low-power modes of a CAN controller. Software asks for initialization mode with a level request and for sleep mode with set and clear strobes. The block answers each request with its own acknowledge flag once the mode has actually been entered. A mode counts as active only while its request and its acknowledge are both high. CPU write strobes aimed at the bit-timing, control and acceptance-filter registers are passed on only while initialization mode is active.

While the controller sleeps, the received CAN line is synchronized and watched for dominant (low) activity. If wake-up is enabled, that activity wakes the controller. A selectable filter can demand that the dominant level persist for a programmable number of clock cycles before it counts. On a wake-up the block raises a one-cycle interrupt and drops both the sleep request and the sleep acknowledge together.

Top module: `can_mode_ctrl`

## Requirements
- R1: `init_ack` goes to 1 one clock after `init_req` is sampled high and goes to 0 one clock after `init_req` is sampled low.
- R2: Initialization mode is active only when `init_req` and `init_ack` are both 1. `init_ack` reads 0 while the controller runs normally.
- R3: `cfg_wr_en` is 1 for exactly the cycle after a `cpu_cfg_wr` strobe that was sampled while initialization mode was active. A strobe sampled at any other time produces no pulse.
- R4: A sampled `sleep_set` makes `sleep_req` read 1 on the next cycle. A sampled `sleep_clr` makes it read 0 on the next cycle, and `sleep_clr` wins over `sleep_set` when both are sampled together.
- R5: `sleep_ack` goes to 1 one clock after a cycle in which `sleep_req` is 1 and `bus_idle` is 1. It goes to 0 one clock after `sleep_req` reads 0.
- R6: With `wake_filt` = 0 and `wake_en` = 1, any synchronized dominant sample (`rx` = 0) while sleep mode is active causes a wake-up.
- R7: With `wake_filt` = 1, a wake-up needs `twup_cycles` consecutive synchronized dominant samples (a value of 0 acts as 1). A return to recessive restarts the count, and shorter dominant pulses are ignored.
- R8: A wake-up gives a `wake_irq` pulse one cycle long, and `sleep_req` and `sleep_ack` read 0 in that same cycle.
- R9: With `wake_en` = 0, dominant activity during sleep leaves `sleep_req` and `sleep_ack` at 1 and raises no `wake_irq`.
- R10: `rx` passes through a two-flop synchronizer. In unfiltered mode, `wake_irq` appears three clock edges after the edge that first samples `rx` low. In filtered mode it appears 2 + `twup_cycles` edges after that edge.
- R11: After reset, every output reads 0 and the synchronizer holds the recessive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| init_req | input | 1 | Initialization mode request level |
| sleep_set | input | 1 | Strobe that sets the sleep request |
| sleep_clr | input | 1 | Strobe that clears the sleep request |
| wake_en | input | 1 | Allows bus activity to wake the controller |
| wake_filt | input | 1 | 1 selects the minimum-length dominant filter |
| twup_cycles | input | CNT_W | Minimum dominant length in clock cycles |
| rx | input | 1 | Asynchronous CAN receive line, 0 is dominant |
| bus_idle | input | 1 | Bus idle status from the protocol engine |
| cpu_cfg_wr | input | 1 | CPU write strobe to the protected configuration registers |
| init_ack | output | 1 | Initialization mode acknowledge |
| sleep_req | output | 1 | Current sleep request |
| sleep_ack | output | 1 | Sleep mode acknowledge |
| wake_irq | output | 1 | One-cycle wake-up interrupt |
| cfg_wr_en | output | 1 | Qualified configuration write strobe |

## Verification
The hardest case to reach from the ports is a dominant glitch that falls just short of the filter length, followed by a pulse that is long enough. Reaching it takes a controller that is already asleep, a programmed length, and exact control of how many cycles `rx` stays low after the synchronizer. The stimulus first parks the block in sleep with the bus idle. It then drives a short low pulse and a recessive gap, and measures the edge count from the next falling `rx` to `wake_irq`. The same pulse is also replayed with wake-up disabled and with a zero filter length.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
  parameter logic RX_DOMINANT = 1'b0;
  parameter logic RX_RECESSIVE = 1'b1;
endpackage

// File: rtl/can_rx_sync.sv
module can_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  import can_mode_pkg::*;
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh <= RX_RECESSIVE;
        else     sh <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RX_RECESSIVE}};
        else     sh <= {sh[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sh[STAGES-1];
endmodule

// File: rtl/can_wake_filter.sv
module can_wake_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_s,
  input  logic             armed,
  input  logic             filt_en,
  input  logic [CNT_W-1:0] twup,
  output logic             hit
);
  import can_mode_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   thr;
  logic [CNT_W:0]   cnt_inc;
  logic             dom;

  assign dom     = (rx_s == RX_DOMINANT);
  assign thr     = (twup == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, twup};
  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign hit     = armed && dom && (!filt_en || (cnt_inc >= thr));

  always_ff @(posedge clk) begin
    if (rst || !armed || !dom) cnt <= '0;
    else if (cnt != CNT_MAX)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/can_sleep_hs.sv
module can_sleep_hs (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic bus_idle,
  input  logic wake_hit,
  output logic req,
  output logic ack,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req <= 1'b0;
      ack <= 1'b0;
      irq <= 1'b0;
    end else begin
      irq <= wake_hit;
      if (clr_req || wake_hit) req <= 1'b0;
      else if (set_req)        req <= 1'b1;
      if (!req || wake_hit)    ack <= 1'b0;
      else if (bus_idle)       ack <= 1'b1;
    end
  end
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_req,
  input  logic             sleep_set,
  input  logic             sleep_clr,
  input  logic             wake_en,
  input  logic             wake_filt,
  input  logic [CNT_W-1:0] twup_cycles,
  input  logic             rx,
  input  logic             bus_idle,
  input  logic             cpu_cfg_wr,
  output logic             init_ack,
  output logic             sleep_req,
  output logic             sleep_ack,
  output logic             wake_irq,
  output logic             cfg_wr_en
);
  logic rx_s;
  logic armed;
  logic hit;

  can_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rx), .q(rx_s)
  );

  assign armed = sleep_req && sleep_ack && wake_en;

  can_wake_filter #(.CNT_W(CNT_W)) u_filt (
    .clk(clk), .rst(rst), .rx_s(rx_s), .armed(armed),
    .filt_en(wake_filt), .twup(twup_cycles), .hit(hit)
  );

  can_sleep_hs u_sleep (
    .clk(clk), .rst(rst), .set_req(sleep_set), .clr_req(sleep_clr),
    .bus_idle(bus_idle), .wake_hit(hit),
    .req(sleep_req), .ack(sleep_ack), .irq(wake_irq)
  );

  // initialization handshake and configuration write gate
  always_ff @(posedge clk) begin
    if (rst) begin
      init_ack  <= 1'b0;
      cfg_wr_en <= 1'b0;
    end else begin
      init_ack  <= init_req;
      cfg_wr_en <= cpu_cfg_wr && init_req && init_ack;
    end
  end
endmodule

// File: rtl/can_mode_chk.sv
module can_mode_chk (
  input logic clk,
  input logic rst,
  input logic init_req,
  input logic init_ack,
  input logic cpu_cfg_wr,
  input logic cfg_wr_en,
  input logic sleep_req,
  input logic sleep_ack,
  input logic wake_irq,
  input logic wake_en
);
  a_r1_ack_rise: assert property (@(posedge clk) disable iff (rst)
    init_req |=> init_ack);
  a_r1_ack_fall: assert property (@(posedge clk) disable iff (rst)
    !init_req |=> !init_ack);
  a_r3_wr_pass: assert property (@(posedge clk) disable iff (rst)
    (cpu_cfg_wr && init_req && init_ack) |=> cfg_wr_en);
  a_r3_wr_block: assert property (@(posedge clk) disable iff (rst)
    !(cpu_cfg_wr && init_req && init_ack) |=> !cfg_wr_en);
  a_r5_ack_drop: assert property (@(posedge clk) disable iff (rst)
    !sleep_req |=> !sleep_ack);
  a_r8_wake_clears: assert property (@(posedge clk) disable iff (rst)
    wake_irq |-> (!sleep_req && !sleep_ack));
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (rst)
    wake_irq |=> !wake_irq);
  a_r9_no_wake_disabled: assert property (@(posedge clk) disable iff (rst)
    !wake_en |=> !wake_irq);
endmodule

bind can_mode_ctrl can_mode_chk u_chk (
  .clk(clk), .rst(rst), .init_req(init_req), .init_ack(init_ack),
  .cpu_cfg_wr(cpu_cfg_wr), .cfg_wr_en(cfg_wr_en), .sleep_req(sleep_req),
  .sleep_ack(sleep_ack), .wake_irq(wake_irq), .wake_en(wake_en)
);

// File: tb/can_mode_ctrl_tb.sv
module can_mode_ctrl_tb;
  localparam int CW = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_req = 0, sleep_set = 0, sleep_clr = 0, wake_en = 0, wake_filt = 0;
  logic [CW-1:0] twup_cycles = '0;
  logic rx = 1'b1, bus_idle = 0, cpu_cfg_wr = 0;
  logic init_ack, sleep_req, sleep_ack, wake_irq, cfg_wr_en;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model state
  int m_s1 = 1, m_s2 = 1, m_cnt = 0;
  bit m_iack = 0, m_cfg = 0, m_req = 0, m_ack = 0, m_irq = 0;

  always #4 clk = ~clk;

  can_mode_ctrl #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .init_req(init_req), .sleep_set(sleep_set),
    .sleep_clr(sleep_clr), .wake_en(wake_en), .wake_filt(wake_filt),
    .twup_cycles(twup_cycles), .rx(rx), .bus_idle(bus_idle),
    .cpu_cfg_wr(cpu_cfg_wr), .init_ack(init_ack), .sleep_req(sleep_req),
    .sleep_ack(sleep_ack), .wake_irq(wake_irq), .cfg_wr_en(cfg_wr_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit hit, dom, armed;
    int thr;
    if (rst) begin
      m_s1 = 1; m_s2 = 1; m_cnt = 0;
      m_iack = 0; m_cfg = 0; m_req = 0; m_ack = 0; m_irq = 0;
    end else begin
      dom   = (m_s2 == 0);
      armed = m_req && m_ack && wake_en;
      thr   = (twup_cycles == 0) ? 1 : int'(twup_cycles);
      hit   = armed && dom && (!wake_filt || (m_cnt + 1 >= thr));
      m_cnt = (armed && dom) ? m_cnt + 1 : 0;
      m_s2  = m_s1;
      m_s1  = int'(rx);
      m_cfg = cpu_cfg_wr && init_req && m_iack;
      m_iack = init_req;
      if (!m_req || hit) m_ack = 0;
      else if (bus_idle) m_ack = 1;
      if (sleep_clr || hit) m_req = 0;
      else if (sleep_set)   m_req = 1;
      m_irq = hit;
    end
    #2;
    if (!done) begin
      chk(init_ack == m_iack, "R1 init_ack", init_ack, m_iack);
      chk(cfg_wr_en == m_cfg, "R3 cfg_wr_en", cfg_wr_en, m_cfg);
      chk(sleep_req == m_req, "R4 sleep_req", sleep_req, m_req);
      chk(sleep_ack == m_ack, "R5 sleep_ack", sleep_ack, m_ack);
      chk(wake_irq == m_irq, "R8 wake_irq", wake_irq, m_irq);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    sleep_set = 1; bus_idle = 1; step(1);
    sleep_set = 0; step(2);
  endtask

  task automatic wake_latency(output int n);
    rx = 0; n = 0;
    for (int i = 0; i < 60; i++) begin
      step(1); n++;
      if (wake_irq) break;
    end
    rx = 1;
  endtask

  initial begin
    int lat;
    step(3);
    rst = 0;
    step(1);
    // R11 reset state
    chk({init_ack, sleep_req, sleep_ack, wake_irq, cfg_wr_en} == 5'b0,
        "R11 reset outputs", {init_ack, sleep_req, sleep_ack, wake_irq, cfg_wr_en}, 0);

    // R1 / R2 / R3 init handshake and write gate
    cpu_cfg_wr = 1; step(1);
    cpu_cfg_wr = 0;
    chk(cfg_wr_en == 0, "R3 write blocked when running", cfg_wr_en, 0);
    chk(init_ack == 0, "R2 ack low when running", init_ack, 0);
    init_req = 1; step(1);
    chk(init_ack == 1, "R1 ack one clock after request", init_ack, 1);
    cpu_cfg_wr = 1; step(1);
    cpu_cfg_wr = 0;
    chk(cfg_wr_en == 1, "R3 write passes in init mode", cfg_wr_en, 1);
    step(1);
    chk(cfg_wr_en == 0, "R3 pulse one cycle", cfg_wr_en, 0);
    init_req = 0; cpu_cfg_wr = 1; step(1);
    cpu_cfg_wr = 0;
    chk(cfg_wr_en == 0, "R2 request low means inactive", cfg_wr_en, 0);
    chk(init_ack == 0, "R1 ack drops one clock after request", init_ack, 0);

    // R4 / R5 sleep handshake
    bus_idle = 0; sleep_set = 1; step(1);
    sleep_set = 0;
    chk(sleep_req == 1, "R4 set strobe", sleep_req, 1);
    step(3);
    chk(sleep_ack == 0, "R5 no ack while bus busy", sleep_ack, 0);
    bus_idle = 1; step(1);
    chk(sleep_ack == 1, "R5 ack after idle", sleep_ack, 1);
    sleep_set = 1; sleep_clr = 1; step(1);
    sleep_set = 0; sleep_clr = 0;
    chk(sleep_req == 0, "R4 clear wins", sleep_req, 0);
    step(1);
    chk(sleep_ack == 0, "R5 ack drops after request", sleep_ack, 0);

    // R9 wake disabled
    go_sleep();
    wake_en = 0; rx = 0; step(10);
    chk(sleep_ack == 1 && sleep_req == 1, "R9 stays asleep", sleep_ack, 1);
    rx = 1; step(4);

    // R7 filtered: short glitch ignored, then full length
    wake_en = 1; wake_filt = 1; twup_cycles = 8'd6;
    rx = 0; step(4); rx = 1; step(4);
    rx = 0; step(5); rx = 1; step(4);
    chk(sleep_ack == 1, "R7 short pulses ignored", sleep_ack, 1);
    wake_latency(lat);
    chk(lat == 8, "R7 R10 filtered latency", lat, 8);
    chk(sleep_req == 0 && sleep_ack == 0, "R8 wake clears pair", sleep_ack, 0);
    step(1);
    chk(wake_irq == 0, "R8 single cycle pulse", wake_irq, 0);
    step(3);

    // R6 / R10 unfiltered
    go_sleep();
    wake_filt = 0;
    wake_latency(lat);
    chk(lat == 3, "R6 R10 unfiltered latency", lat, 3);
    step(3);

    // R7 zero length acts as one
    go_sleep();
    wake_filt = 1; twup_cycles = 8'd0;
    wake_latency(lat);
    chk(lat == 3, "R7 zero length", lat, 3);
    step(4);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule